// File: doc/BRIEF.md
# GPS Pulse-Per-Second Oscillator Disciplining Loop

This block steers a reference oscillator so that its phase stays locked to a satellite-derived one-pulse-per-second timing mark. Each second it measures the delay from the timing pulse to the next edge of a prescaled copy of the oscillator. The delay is counted in cycles of the fast measurement clock `clk`. The oscillator is divided by 32 outside the block before it reaches `osc_div_in`. At nominal rates one measurement count is about 41.7 ns, so one unit of a full-window total is about 1.39 ns of phase. The block adds these delays over a window of `WINDOW` pulses, 30 by default. At the end of each window it runs a digital loop filter once and updates a signed DAC control code. An external converter turns that code into the oscillator's control voltage.

A three-bit filter mode picks the loop behaviour. Mode 0 is a setup mode that parks the code at zero and lights lamps showing the frequency trend. Mode 1 is a first-order loop. Modes 2 to 7 are proportional-plus-integral loops whose time constant doubles at each step. The mode may be changed at any time without a reset. The loop holds the window total at a setpoint, 800 by default. The offset leaves room to track phase moving either way. The block also has:
- a polarity input, for oscillators whose frequency falls as the control code rises;
- an open-loop input that freezes the code while measurement and flags carry on;
- a jump rejector that discards a reading which differs too much from the previous window's total.

`pps_in` and `osc_div_in` are taken to be already synchronous to `clk`.

Top module: `gps_pps_discipline`

## Requirements
- R1: A phase reading equals the number of `clk` rising edges from the edge that first samples `pps_in` high to the edge that first samples `osc_div_in` high after it. A window total is the sum of `WINDOW` consecutive readings. `dac_code` and the flags change only once per window, a few cycles after its last reading.
- R2: After reset, `dac_code` is 0 and all four flag outputs are low. The first window after reset has no previous total, so it can raise neither a trend lamp nor a rejection.
- R3: In mode 0 with the loop closed, a window sets `dac_code` to 0 and clears the integrator. `lamp_high` lights when the total is below the previous total, meaning the oscillator is running fast. `lamp_low` lights when the total is above the previous total.
- R4: In mode 1, `dac_code` becomes sat(e·2^KP1_SHL), and the integrator is loaded with that same value.
- R5: In modes m = 2..7, with s = m−2, the integrator becomes sat(I + floor(e·2^KI_BASE / 2^(2s))). `dac_code` then becomes sat(I_new + floor(e·2^KP_BASE / 2^s)).
- R6: With `pol_pos`=1 the error is e = total − SETPOINT. With `pol_pos`=0 the error is e = SETPOINT − total.
- R7: sat() clamps to the signed `DAC_W`-bit range, −2^(DAC_W−1) to 2^(DAC_W−1)−1, and the integrator is clamped to the same range.
- R8: With `loop_open`=1, `dac_code` and the integrator stay unchanged at window ends. The flags and lamps still update.
- R9: `unlock_flag` is high when |total − SETPOINT| > UNLOCK_TH. In modes 1..7, `lamp_high` equals `unlock_flag`.
- R10: In modes 4..7, a window whose total differs from the previous total by more than GLITCH_TH is discarded: the code and integrator are unchanged, and `deglitch_flag` and `lamp_low` are high. That total still becomes the new previous total. In modes 1..3 no window is discarded, and `deglitch_flag` and `lamp_low` are low.
- R11: A change of `filt_mode` takes effect at the next window end. The integrator carries over, so a second-order loop continues from the value that mode 1 or an earlier mode left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | One-pulse-per-second timing mark |
| osc_div_in | input | 1 | Prescaled oscillator (oscillator divided by 32) |
| filt_mode | input | 3 | Loop mode: 0 setup, 1 first order, 2..7 second order |
| pol_pos | input | 1 | 1 when frequency rises with the control code |
| loop_open | input | 1 | 1 freezes the control code |
| dac_code | output | DAC_W | Signed control code for the DAC |
| lamp_high | output | 1 | Fast-trend lamp (mode 0) or far-from-setpoint lamp |
| lamp_low | output | 1 | Slow-trend lamp (mode 0) or rejected-jump lamp |
| deglitch_flag | output | 1 | Last window total was discarded |
| unlock_flag | output | 1 | Last window total was far from the setpoint |

## Verification
The hardest conditions to reach from the ports are a saturated integrator and a rejected jump during a mode change. Both depend on history built up over many windows. The bench uses a small configuration: three readings per window, a 12-bit code, a setpoint of 30 and thresholds of 12 and 6. This lets it step through every mode under both polarities and both loop states within a few hundred windows. A running arithmetic model of the code, integrator and previous total predicts every window's outputs. A long run of large errors drives the code into both clamps. Jumps between modes 3 and 4 check that rejection starts exactly at mode 4.

// File: rtl/gps_pps_pkg.sv
package gps_pps_pkg;

    typedef logic signed [39:0] wide_t;

    typedef enum logic [1:0] {
        LOOP_SETUP  = 2'd0,
        LOOP_FIRST  = 2'd1,
        LOOP_SECOND = 2'd2
    } loop_kind_e;

    typedef struct packed {
        logic lamp_hi;
        logic lamp_lo;
        logic deglitch;
        logic unlock;
    } loop_flags_t;

    function automatic loop_kind_e loop_kind(input logic [2:0] m);
        case (m)
            3'd0:    return LOOP_SETUP;
            3'd1:    return LOOP_FIRST;
            default: return LOOP_SECOND;
        endcase
    endfunction

    function automatic wide_t abs_w(input wide_t v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic wide_t sat_w(input wide_t v, input int w);
        wide_t hi;
        wide_t lo;
        hi = (wide_t'(1) <<< (w - 1)) - wide_t'(1);
        lo = -hi - wide_t'(1);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

endpackage

// File: rtl/pps_phase_meter.sv
module pps_phase_meter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pps_i,
    input  logic             osc_i,
    output logic             rd_valid_o,
    output logic [CNT_W-1:0] rd_count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             pps_q, osc_q, busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pps_rise, osc_rise;

    assign pps_rise = pps_i & ~pps_q;
    assign osc_rise = osc_i & ~osc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pps_q      <= 1'b0;
            osc_q      <= 1'b0;
            busy_q     <= 1'b0;
            cnt_q      <= '0;
            rd_valid_o <= 1'b0;
            rd_count_o <= '0;
        end else begin
            pps_q      <= pps_i;
            osc_q      <= osc_i;
            rd_valid_o <= 1'b0;
            if (pps_rise) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_W'(1);
            end else if (busy_q) begin
                if (osc_rise) begin
                    busy_q     <= 1'b0;
                    rd_valid_o <= 1'b1;
                    rd_count_o <= cnt_q;
                end else if (cnt_q != CNT_MAX) begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    // R1: a reading is produced only by an oscillator edge while measuring
    a_r1_reading_needs_edge: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> $past(busy_q) && $past(osc_rise));

endmodule

// File: rtl/phase_window_acc.sv
module phase_window_acc #(
    parameter int CNT_W  = 8,
    parameter int WINDOW = 30,
    parameter int SUM_W  = CNT_W + $clog2(WINDOW + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_valid_i,
    input  logic [CNT_W-1:0] rd_count_i,
    output logic             tot_valid_o,
    output logic [SUM_W-1:0] total_o
);
    localparam int NW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [NW-1:0] LAST = NW'(WINDOW - 1);

    logic [SUM_W-1:0] sum_q;
    logic [NW-1:0]    n_q;
    logic [SUM_W-1:0] sum_n;

    assign sum_n = sum_q + SUM_W'(rd_count_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q       <= '0;
            n_q         <= '0;
            tot_valid_o <= 1'b0;
            total_o     <= '0;
        end else begin
            tot_valid_o <= 1'b0;
            if (rd_valid_i) begin
                if (n_q == LAST) begin
                    total_o     <= sum_n;
                    tot_valid_o <= 1'b1;
                    sum_q       <= '0;
                    n_q         <= '0;
                end else begin
                    sum_q <= sum_n;
                    n_q   <= n_q + NW'(1);
                end
            end
        end
    end

    // R1: one window end is a single-cycle event
    a_r1_single_total: assert property (@(posedge clk) disable iff (rst)
        tot_valid_o |=> !tot_valid_o);

endmodule

// File: rtl/pll_loop_filter.sv
module pll_loop_filter
    import gps_pps_pkg::*;
#(
    parameter int SUM_W     = 13,
    parameter int DAC_W     = 18,
    parameter int SETPOINT  = 800,
    parameter int UNLOCK_TH = 200,
    parameter int GLITCH_TH = 100,
    parameter int KP1_SHL   = 6,
    parameter int KP_BASE   = 8,
    parameter int KI_BASE   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tot_valid_i,
    input  logic [SUM_W-1:0] total_i,
    input  logic [2:0]       mode_i,
    input  logic             pol_pos_i,
    input  logic             loop_open_i,
    output wide_t            dac_o,
    output loop_flags_t      flags_o
);
    localparam wide_t DMAX = (wide_t'(1) <<< (DAC_W - 1)) - wide_t'(1);
    localparam wide_t DMIN = -DMAX - wide_t'(1);

    wide_t       dac_q, integ_q, prev_q;
    logic        have_q;
    loop_flags_t flags_q;

    wide_t       tot_w, err, e, diff, prop, step, dac_n, integ_n;
    logic [2:0]  sh;
    logic        jump, reject, off_lock;
    loop_kind_e  kind;
    loop_flags_t flags_n;

    always_comb begin
        tot_w    = wide_t'(total_i);
        err      = tot_w - wide_t'(SETPOINT);
        e        = pol_pos_i ? err : -err;
        diff     = tot_w - prev_q;
        kind     = loop_kind(mode_i);
        jump     = have_q && (abs_w(diff) > wide_t'(GLITCH_TH));
        reject   = jump && (mode_i >= 3'd4);
        off_lock = abs_w(err) > wide_t'(UNLOCK_TH);
        sh       = mode_i - 3'd2;
        prop     = (e <<< KP_BASE) >>> sh;
        step     = (e <<< KI_BASE) >>> {sh, 1'b0};
        integ_n  = integ_q;
        dac_n    = dac_q;
        case (kind)
            LOOP_SETUP: begin
                integ_n = '0;
                dac_n   = '0;
            end
            LOOP_FIRST: begin
                dac_n   = sat_w(e <<< KP1_SHL, DAC_W);
                integ_n = dac_n;
            end
            default: begin
                if (!reject) begin
                    integ_n = sat_w(integ_q + step, DAC_W);
                    dac_n   = sat_w(integ_n + prop, DAC_W);
                end
            end
        endcase
        if (loop_open_i) begin
            integ_n = integ_q;
            dac_n   = dac_q;
        end
        flags_n.lamp_hi  = (kind == LOOP_SETUP) ? (have_q && (tot_w < prev_q)) : off_lock;
        flags_n.lamp_lo  = (kind == LOOP_SETUP) ? (have_q && (tot_w > prev_q)) : reject;
        flags_n.deglitch = reject;
        flags_n.unlock   = off_lock;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_q   <= '0;
            integ_q <= '0;
            prev_q  <= '0;
            have_q  <= 1'b0;
            flags_q <= '0;
        end else if (tot_valid_i) begin
            dac_q   <= dac_n;
            integ_q <= integ_n;
            prev_q  <= tot_w;
            have_q  <= 1'b1;
            flags_q <= flags_n;
        end
    end

    assign dac_o   = dac_q;
    assign flags_o = flags_q;

    // R1: the code moves only at a window end
    a_r1_code_quiet: assert property (@(posedge clk) disable iff (rst)
        !tot_valid_i |=> $stable(dac_q));
    // R8: an open loop freezes code and integrator
    a_r8_open_freeze: assert property (@(posedge clk) disable iff (rst)
        tot_valid_i && loop_open_i |=> $stable(dac_q) && $stable(integ_q));
    // R3: setup mode parks the code at zero
    a_r3_setup_zero: assert property (@(posedge clk) disable iff (rst)
        tot_valid_i && !loop_open_i && (mode_i == 3'd0) |=> (dac_q == '0) && (integ_q == '0));
    // R10: no rejection below mode 4
    a_r10_low_modes_keep: assert property (@(posedge clk) disable iff (rst)
        tot_valid_i && (mode_i inside {3'd1, 3'd2, 3'd3}) |=> !flags_q.deglitch && !flags_q.lamp_lo);
    // R9: high lamp follows the unlock flag outside setup
    a_r9_high_is_unlock: assert property (@(posedge clk) disable iff (rst)
        tot_valid_i && (mode_i != 3'd0) |=> flags_q.lamp_hi == flags_q.unlock);
    // R7: code and integrator stay inside the signed range
    a_r7_in_range: assert property (@(posedge clk) disable iff (rst)
        (dac_q <= DMAX) && (dac_q >= DMIN) && (integ_q <= DMAX) && (integ_q >= DMIN));

endmodule

// File: rtl/gps_pps_discipline.sv
module gps_pps_discipline
    import gps_pps_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int WINDOW    = 30,
    parameter int DAC_W     = 18,
    parameter int SETPOINT  = 800,
    parameter int UNLOCK_TH = 200,
    parameter int GLITCH_TH = 100,
    parameter int KP1_SHL   = 6,
    parameter int KP_BASE   = 8,
    parameter int KI_BASE   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pps_in,
    input  logic             osc_div_in,
    input  logic [2:0]       filt_mode,
    input  logic             pol_pos,
    input  logic             loop_open,
    output logic [DAC_W-1:0] dac_code,
    output logic             lamp_high,
    output logic             lamp_low,
    output logic             deglitch_flag,
    output logic             unlock_flag
);
    localparam int SUM_W = CNT_W + $clog2(WINDOW + 1);

    logic             rd_valid, tot_valid;
    logic [CNT_W-1:0] rd_count;
    logic [SUM_W-1:0] total;
    wide_t            dac_w;
    loop_flags_t      flags;

    pps_phase_meter #(.CNT_W(CNT_W)) u_meter (
        .clk        (clk),
        .rst        (rst),
        .pps_i      (pps_in),
        .osc_i      (osc_div_in),
        .rd_valid_o (rd_valid),
        .rd_count_o (rd_count)
    );

    phase_window_acc #(.CNT_W(CNT_W), .WINDOW(WINDOW), .SUM_W(SUM_W)) u_acc (
        .clk         (clk),
        .rst         (rst),
        .rd_valid_i  (rd_valid),
        .rd_count_i  (rd_count),
        .tot_valid_o (tot_valid),
        .total_o     (total)
    );

    pll_loop_filter #(
        .SUM_W(SUM_W), .DAC_W(DAC_W), .SETPOINT(SETPOINT),
        .UNLOCK_TH(UNLOCK_TH), .GLITCH_TH(GLITCH_TH),
        .KP1_SHL(KP1_SHL), .KP_BASE(KP_BASE), .KI_BASE(KI_BASE)
    ) u_filter (
        .clk         (clk),
        .rst         (rst),
        .tot_valid_i (tot_valid),
        .total_i     (total),
        .mode_i      (filt_mode),
        .pol_pos_i   (pol_pos),
        .loop_open_i (loop_open),
        .dac_o       (dac_w),
        .flags_o     (flags)
    );

    assign dac_code      = dac_w[DAC_W-1:0];
    assign lamp_high     = flags.lamp_hi;
    assign lamp_low      = flags.lamp_lo;
    assign deglitch_flag = flags.deglitch;
    assign unlock_flag   = flags.unlock;

    // R2: reset clears code and flags
    a_r2_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (dac_code == '0) && !lamp_high && !lamp_low && !deglitch_flag && !unlock_flag);

endmodule

// File: tb/gps_pps_discipline_tb.sv
module gps_pps_discipline_tb;
    localparam int WIN = 3, DW = 12, SP = 30, UT = 12, GT = 6, K1 = 2, KP = 4, KI = 3;
    localparam longint LIM = (64'sd1 <<< (DW - 1)) - 1;

    logic clk = 1'b0, rst = 1'b1, pps = 1'b0, osc = 1'b0;
    logic [2:0] mode = 3'd0;
    logic pol = 1'b1, hold = 1'b0;
    logic [DW-1:0] dac;
    logic lhi, llo, dgl, unl;

    int n_chk = 0, n_fail = 0;
    longint m_dac = 0, m_int = 0, m_prev = 0;
    bit m_have = 0;

    always #10 clk = ~clk;

    gps_pps_discipline #(
        .CNT_W(6), .WINDOW(WIN), .DAC_W(DW), .SETPOINT(SP), .UNLOCK_TH(UT),
        .GLITCH_TH(GT), .KP1_SHL(K1), .KP_BASE(KP), .KI_BASE(KI)
    ) u_dut (
        .clk(clk), .rst(rst), .pps_in(pps), .osc_div_in(osc), .filt_mode(mode),
        .pol_pos(pol), .loop_open(hold), .dac_code(dac), .lamp_high(lhi),
        .lamp_low(llo), .deglitch_flag(dgl), .unlock_flag(unl)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint sat(input longint v);
        if (v > LIM) return LIM;
        if (v < -LIM - 1) return -LIM - 1;
        return v;
    endfunction

    function automatic longint absl(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic one_read(input int d);
        @(negedge clk) pps = 1'b1;
        repeat (d) @(negedge clk);
        osc = 1'b1;
        @(negedge clk);
        pps = 1'b0;
        osc = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_window(input int d0, input int d1, input int d2);
        longint t, err, e, diff, prop, step;
        bit jump, rej, offl, xhi, xlo;
        string ct;
        int s;
        one_read(d0);
        chk("R1 code stable inside window", longint'($signed(dac)), m_dac);
        one_read(d1);
        one_read(d2);
        repeat (4) @(negedge clk);
        t    = d0 + d1 + d2;
        err  = t - SP;
        e    = pol ? err : -err;
        diff = t - m_prev;
        jump = m_have && (absl(diff) > GT);
        rej  = jump && (mode >= 3'd4);
        offl = absl(err) > UT;
        s    = int'(mode) - 2;
        if (!hold) begin
            if (mode == 3'd0) begin
                m_dac = 0; m_int = 0;
            end else if (mode == 3'd1) begin
                m_dac = sat(e <<< K1); m_int = m_dac;
            end else if (!rej) begin
                step  = (e <<< KI) >>> (2 * s);
                prop  = (e <<< KP) >>> s;
                m_int = sat(m_int + step);
                m_dac = sat(m_int + prop);
            end
        end
        if (mode == 3'd0) begin
            xhi = m_have && (t < m_prev);
            xlo = m_have && (t > m_prev);
        end else begin
            xhi = offl;
            xlo = rej;
        end
        m_prev = t;
        m_have = 1;
        if (hold) ct = "R8 code held";
        else if (mode == 3'd0) ct = "R3 setup code";
        else if (mode == 3'd1) ct = pol ? "R4 first order" : "R6 polarity first order";
        else ct = pol ? "R5 second order" : "R6 polarity second order";
        chk(ct, longint'($signed(dac)), m_dac);
        chk(mode == 3'd0 ? "R3 high lamp" : "R9 high lamp", longint'(lhi), longint'(xhi));
        chk(mode == 3'd0 ? "R3 low lamp" : "R10 low lamp", longint'(llo), longint'(xlo));
        chk("R10 deglitch flag", longint'(dgl), longint'(rej));
        chk("R9 unlock flag", longint'(unl), longint'(offl));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        chk("R2 reset code", longint'($signed(dac)), 0);
        chk("R2 reset lamps", longint'({lhi, llo, dgl, unl}), 0);

        // R3 setup trend lamps; first window has no previous total (R2)
        mode = 3'd0;
        run_window(10, 10, 10);
        run_window(9, 9, 9);
        run_window(11, 12, 11);
        run_window(11, 12, 11);

        // R1 summation of unequal readings, R4 first order, R6 polarity
        mode = 3'd1;
        run_window(5, 10, 15);
        for (int p = 1; p >= 0; p--) begin
            pol = p[0];
            for (int d = 6; d <= 15; d++) run_window(d, d, d);
        end

        // R5 and R11: sweep second-order modes, both polarities, mode changes on the fly
        for (int m = 2; m <= 7; m++) begin
            mode = 3'(m);
            for (int p = 0; p < 2; p++) begin
                pol = p[0];
                run_window(11, 11, 11);
                run_window(12, 12, 12);
                run_window(9, 9, 9);
                run_window(10, 11, 10);
            end
        end

        // R10 boundary: jump of 9 in mode 3 accepted, same jump in mode 4 rejected
        pol  = 1'b1;
        mode = 3'd3;
        run_window(10, 10, 10);
        run_window(13, 13, 13);
        mode = 3'd4;
        run_window(10, 10, 10);
        run_window(12, 12, 12);
        run_window(14, 14, 14);

        // R7 saturation both ways in mode 2
        mode = 3'd2;
        for (int i = 0; i < 14; i++) run_window(25, 25, 25);
        chk("R7 upper clamp", longint'($signed(dac)), LIM);
        pol = 1'b0;
        for (int i = 0; i < 20; i++) run_window(25, 25, 25);
        chk("R7 lower clamp", longint'($signed(dac)), -LIM - 1);

        // R8 open loop: code frozen while flags move
        hold = 1'b1;
        pol  = 1'b1;
        run_window(10, 10, 10);
        run_window(20, 20, 20);
        mode = 3'd5;
        run_window(5, 5, 5);
        mode = 3'd0;
        run_window(7, 7, 7);
        mode = 3'd1;
        run_window(14, 14, 14);
        hold = 1'b0;
        run_window(14, 14, 14);

        // R11 integrator carried from mode 1 into mode 6
        mode = 3'd6;
        run_window(12, 12, 12);
        run_window(11, 11, 11);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule